// File: doc/BRIEF.md
# Cell Header HEC Generator

This block computes the 8-bit header error control byte of a cell header. A
header arrives as four bytes, one per accepted clock cycle, on a byte-wide input
qualified by a valid flag. A start flag marks the first byte. The 32 header bits
are run through a CRC-8 with generator polynomial x^8 + x^2 + x + 1. The CRC
register starts at zero. The final remainder is XORed with the constant 0x55, and
the result is presented together with a one-cycle done strobe.

With the check option enabled, the byte that follows the fourth header byte is
taken as the received HEC. It is compared against the computed value, and a
one-cycle error strobe reports a mismatch. Error correction, cell delineation and
payload scrambling are handled elsewhere.

Top module: `hec_gen`

## Requirements
- R1: While reset is asserted and after it is released with no input, `hecValid` and `hecErr` are 0 and `hecOut` is 0x00.
- R2: `hecOut` equals the CRC-8 of the 32 header bits XORed with 0x55. The CRC uses polynomial x^8+x^2+x+1 (feedback mask 0x07) and an initial value of zero. The bits are fed most significant bit first, starting with the first byte's bit 7. For example, header 00 00 00 01 gives 0x52 and header 00 00 00 00 gives 0x55.
- R3: Cycles with `inValid` low are ignored. Idle gaps of any length between header bytes do not change the result.
- R4: A byte with `inValid` and `inStart` both high always begins a new header with a cleared CRC register, including in the middle of a header.
- R5: `hecValid` is high for exactly one cycle. It is asserted in the cycle that follows the clock edge at which the fourth header byte is sampled.
- R6: `hecOut` holds its value from one `hecValid` pulse until the next.
- R7: If `checkEn` is high when the fourth byte is sampled, the next valid byte without `inStart` is compared with the computed HEC. On a mismatch, `hecErr` is high for one cycle, in the cycle after that byte is sampled. On a match, `hecErr` stays low.
- R8: If `checkEn` is low at the fourth byte, no comparison takes place. Valid bytes without `inStart` that arrive outside a header cause no `hecValid` and no `hecErr`.
- R9: A start byte that arrives while a check byte is awaited abandons the check and begins a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies `inData` in this cycle |
| inStart | input | 1 | Marks the first byte of a header |
| inData | input | 8 | Header byte, or received HEC in check mode |
| checkEn | input | 1 | Enables comparison of the byte following the header |
| hecValid | output | 1 | One-cycle strobe: `hecOut` is new |
| hecOut | output | 8 | Computed HEC, held until the next result |
| hecErr | output | 1 | One-cycle strobe: received HEC mismatched |

## Verification
`hecValid` and the new `hecOut` are due exactly one cycle after the edge that samples the fourth byte. `hecErr` is due one cycle after the edge that samples the check byte. Both become visible after that edge. The bench updates its reference model at every rising edge from the inputs it drove on the preceding falling edge. It compares all three outputs on every falling edge, so a result that arrives one cycle early or late, or that lasts longer than one cycle, is a miscompare. Stimulus covers gaps, restarts, back-to-back headers and both check outcomes.

// File: rtl/hec_pkg.sv
package hec_pkg;

  // Strobes from the control to the datapath, valid in the cycle a byte is taken.
  typedef struct packed {
    logic clearLoad;    // first byte: seed CRC with zero
    logic accumulate;   // continuing header byte
    logic latchResult;  // last header byte: capture coset result
    logic compare;      // check byte: compare with held result
  } hecStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_COLLECT     = 2'd1,
    ST_AWAIT_CHECK = 2'd2
  } hecState_t;

endpackage

// File: rtl/hec_ctrl.sv
module hec_ctrl
  import hec_pkg::*;
#(
  parameter int HDR_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inStart,
  input  logic        checkEn,
  output hecStrobes_t strobes,
  output logic        doneOut
);

  localparam int CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  hecState_t       stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             doneQ;

  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    cntD    = cntQ;
    if (inValid && inStart) begin
      strobes.clearLoad = 1'b1;
      stateD            = ST_COLLECT;
      cntD              = ONE;
    end else if (inValid) begin
      unique case (stateQ)
        ST_COLLECT: begin
          strobes.accumulate = 1'b1;
          if (cntQ == LAST_IDX) begin
            strobes.latchResult = 1'b1;
            stateD = checkEn ? ST_AWAIT_CHECK : ST_IDLE;
            cntD   = '0;
          end else begin
            cntD = cntQ + ONE;
          end
        end
        ST_AWAIT_CHECK: begin
          strobes.compare = 1'b1;
          stateD          = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      doneQ  <= strobes.latchResult;
    end
  end

  assign doneOut = doneQ;

  initial begin
    if (HDR_BYTES < 2) $error("HDR_BYTES must be at least 2");
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R5

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_COLLECT) |-> (cntQ >= ONE && cntQ <= LAST_IDX)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clearLoad, strobes.accumulate, strobes.compare})); // R4

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inStart) |=> (stateQ == ST_COLLECT && cntQ == ONE)); // R9

endmodule

// File: rtl/hec_datapath.sv
module hec_datapath
  import hec_pkg::*;
#(
  parameter int                 DATA_W = 8,
  parameter int                 CRC_W  = 8,
  parameter logic [CRC_W-1:0]   POLY   = 8'h07,
  parameter logic [CRC_W-1:0]   COSET  = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  hecStrobes_t       strobes,
  output logic [CRC_W-1:0]  resultOut,
  output logic              errOut
);

  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] resultQ;
  logic             errQ;

  // Unrolled bit-serial CRC: one stage per input bit, MSB first.
  logic [CRC_W-1:0] chain [0:DATA_W];

  assign chain[0] = strobes.clearLoad ? '0 : crcQ;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    logic fb;
    assign fb = inData[DATA_W-1-k] ^ chain[k][CRC_W-1];
    assign chain[k+1] = {chain[k][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ    <= '0;
      resultQ <= '0;
      errQ    <= 1'b0;
    end else begin
      if (strobes.clearLoad || strobes.accumulate) crcQ <= chain[DATA_W];
      if (strobes.latchResult) resultQ <= chain[DATA_W] ^ COSET;
      errQ <= strobes.compare && (inData != resultQ[DATA_W-1:0]);
    end
  end

  assign resultOut = resultQ;
  assign errOut    = errQ;

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchResult |=> $stable(resultQ)); // R6

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> !errQ); // R7

  AST_CRC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.clearLoad || strobes.accumulate) |=> $stable(crcQ)); // R3

endmodule

// File: rtl/hec_gen.sv
module hec_gen
  import hec_pkg::*;
#(
  parameter int HDR_BYTES = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inStart,
  input  logic [DATA_W-1:0] inData,
  input  logic              checkEn,
  output logic              hecValid,
  output logic [7:0]        hecOut,
  output logic              hecErr
);

  hecStrobes_t strobes;

  hec_ctrl #(.HDR_BYTES(HDR_BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inStart (inStart),
    .checkEn (checkEn),
    .strobes (strobes),
    .doneOut (hecValid)
  );

  hec_datapath #(.DATA_W(DATA_W), .CRC_W(8), .POLY(8'h07), .COSET(8'h55)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .strobes   (strobes),
    .resultOut (hecOut),
    .errOut    (hecErr)
  );

  AST_ERR_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    hecErr |-> !hecValid); // R7

  AST_DONE_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    !hecValid |-> $stable(hecOut)); // R6

endmodule

// File: tb/tb_hec_gen.sv
module tb_hec_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inStart = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       checkEn = 1'b0;
  logic       hecValid;
  logic [7:0] hecOut;
  logic       hecErr;

  int vecCount = 0;
  int failCount = 0;
  int cycles = 0;
  string curReq = "R1";

  // reference model state
  int         mState = 0;   // 0 idle, 1 collecting, 2 awaiting check byte
  int         mCnt = 0;
  logic [31:0] mHdr = '0;
  logic       expValid = 1'b0;
  logic       expErr = 1'b0;
  logic [7:0] expOut = 8'h00;

  always #5 clk = ~clk;

  hec_gen dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inData(inData), .checkEn(checkEn),
    .hecValid(hecValid), .hecOut(hecOut), .hecErr(hecErr)
  );

  function automatic logic [7:0] hecOf(input logic [31:0] h);
    logic [7:0] r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = h[i] ^ r[7];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r ^ 8'h55;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; expValid = 0; expErr = 0; expOut = 8'h00;
    end else begin
      expValid = 0;
      expErr = 0;
      if (inValid && inStart) begin
        mHdr = {24'h0, inData}; mCnt = 1; mState = 1;
      end else if (inValid) begin
        if (mState == 1) begin
          mHdr = {mHdr[23:0], inData};
          mCnt++;
          if (mCnt == 4) begin
            expOut = hecOf(mHdr);
            expValid = 1;
            mState = checkEn ? 2 : 0;
          end
        end else if (mState == 2) begin
          expErr = (inData != expOut);
          mState = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    vecCount++;
    if (hecValid !== expValid || hecOut !== expOut || hecErr !== expErr) begin
      failCount++;
      $display("FAIL %s t=%0t: valid/out/err actual %b/%h/%b expected %b/%h/%b",
               curReq, $time, hecValid, hecOut, hecErr, expValid, expOut, expErr);
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] b, input logic st);
    inData = b; inStart = st; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic header(input logic [31:0] h, input int spacing);
    for (int i = 3; i >= 0; i--) begin
      putByte(h[8*i +: 8], i == 3);
      if (i != 0) gap(spacing);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({6'b0, hecValid, hecErr}, 8'h00, "R1");
    chk(hecOut, 8'h00, "R1");
    rstN = 1'b1;
    gap(2);
    chk(hecOut, 8'h00, "R1");

    curReq = "R2";
    header(32'h0000_0001, 0);
    gap(1);
    chk(hecOut, 8'h52, "R2");
    header(32'h0000_0000, 0);
    gap(1);
    chk(hecOut, 8'h55, "R2");
    header(32'hDEAD_BEEF, 0);
    header(32'h8000_0000, 0);
    header(32'h1234_5678, 0);
    gap(1);
    chk(hecOut, hecOf(32'h1234_5678), "R2");

    curReq = "R3";
    header(32'hA5C3_0F81, 3);
    gap(2);
    chk(hecOut, hecOf(32'hA5C3_0F81), "R3");

    curReq = "R6";
    gap(6);
    chk(hecOut, hecOf(32'hA5C3_0F81), "R6");

    curReq = "R4";
    putByte(8'hFF, 1); putByte(8'hEE, 0);
    header(32'h0102_0304, 0);
    gap(1);
    chk(hecOut, hecOf(32'h0102_0304), "R4");

    curReq = "R7";
    checkEn = 1'b1;
    header(32'h4B3A_C500, 0);
    putByte(hecOf(32'h4B3A_C500), 0);
    gap(1);
    chk({7'b0, hecErr}, 8'h00, "R7");
    header(32'h0000_0001, 1);
    putByte(8'h53, 0);
    chk({7'b0, hecErr}, 8'h01, "R7");
    gap(2);

    curReq = "R9";
    header(32'h7777_0000, 0);
    header(32'h0000_0001, 0);
    putByte(8'h00, 0);
    gap(2);

    curReq = "R8";
    checkEn = 1'b0;
    header(32'hC5C5_3A3A, 0);
    putByte(8'h00, 0);
    putByte(8'h11, 0);
    gap(1);
    chk({6'b0, hecValid, hecErr}, 8'h00, "R8");
    putByte(8'h22, 0);

    curReq = "R5";
    header(32'h1111_2222, 0);
    header(32'h3333_4444, 0);
    gap(3);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule